// File: doc/BRIEF.md
# Dual-Image Fallback Configuration Controller

This controller chooses which of two stored configuration images a device should load. It runs the load handshake and supervises the loaded image until something forces a reload. After reset it reads an image-select pin and requests a load of that image. It then waits for either a load-complete or a CRC-error response. Once an image is running (user mode), a watchdog counts toward a time-out that the running design must keep restarting.

The first error is either a CRC error or a watchdog time-out. On the first error the controller reloads the other image and marks the load as a revert. A second error leaves it parked until a reconfiguration request arrives. An optional auto-restart setting makes it reload at once instead. Three active-low request lines start a reconfiguration: an external config request, an external status line and a user request. For these requested reloads, a user override can replace the select pin. Each time the running image is left, a record keeps the single highest-priority cause and the 4-bit state code at that moment. Flash access and decompression sit outside the block, behind the load handshake.

Top module: `dual_img_cfg_ctrl`

## Requirements
- R1: `state_o` carries the load code: 0010 for image 0, 0100 for image 1, 0011 for image 1 reached by a revert, 0101 for image 0 reached by a revert, and 0000 only before the first load. While `load_req_o` is high, `load_img_o` is 1 exactly for codes 0100 and 0011.
- R2: In the first cycle after reset is released, the outputs are idle: no load request, not in user mode, not halted, cause 0000, state 0000. On the next clock the controller requests a load of the image given by `sel_pin_i`, and the override is not used for this load.
- R3: `load_done_i` during a load (with no CRC error) drops `load_req_o` and raises `user_mode_o` on the same clock edge.
- R4: A first error reloads the other image with the matching revert code. The error is either `crc_err_i` during a load or in user mode, or a watchdog time-out in user mode.
- R5: An error that occurs after a revert is the second error. It drops the load request and holds `halted_o` until `ext_cfg_n_i`, `ext_sts_n_i` or `usr_cfg_n_i` is low. With AUTO_RESTART set, the controller starts a new load one clock after halting.
- R6: In user mode, a low on `ext_cfg_n_i`, `ext_sts_n_i` or `usr_cfg_n_i` starts a new, non-revert load of the selected image. The request lines are not acted on during a load.
- R7: `prev_cause_o` holds at most one set bit, ordered by priority: bit 3 external config, bit 2 CRC error, bit 1 status, bit 0 watchdog. Only the highest cause present is stored, and `prev_state_o` stores the state code at the event. A user-request-only event stores cause 0000. Leaving the halted state records nothing.
- R8: The watchdog starts at zero when user mode is entered. `wd_timeout_o` pulses for one cycle WD_HI_VAL·2^WD_LO_W clocks later. The default counter width is 12+17 = 29 bits, and only the upper 12 bits are set.
- R9: A falling edge on `wd_kick_n_i` restarts the count from zero. Kicks spaced closer than the limit prevent any time-out.
- R10: With IMG0_ONLY set, every load is image 0 with code 0010, whatever the select pin or override. An error never causes a fallback to image 1.
- R11: For requested reloads, `ovr_sel_i` replaces the select pin when `ovr_en_i` is 1.
- R12: A requested reload that completes clears the revert mark, so the next error reverts again instead of halting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| sel_pin_i | input | 1 | Image-select pin |
| ovr_en_i | input | 1 | Enable the user image override |
| ovr_sel_i | input | 1 | Override image index |
| ext_cfg_n_i | input | 1 | External config request, active low |
| ext_sts_n_i | input | 1 | External status line, active low |
| usr_cfg_n_i | input | 1 | User reconfiguration request, active low |
| wd_kick_n_i | input | 1 | Watchdog restart; falling edge restarts the count |
| load_done_i | input | 1 | Image load completed |
| crc_err_i | input | 1 | CRC error reported |
| load_req_o | output | 1 | Load request |
| load_img_o | output | 1 | Image index to load |
| user_mode_o | output | 1 | Image running in user mode |
| halted_o | output | 1 | Parked after a second error |
| wd_timeout_o | output | 1 | One-cycle watchdog expiry pulse |
| state_o | output | 4 | Current load code |
| prev_cause_o | output | 4 | Recorded cause of leaving the last image |
| prev_state_o | output | 4 | State code at that event |

## Verification
Some properties are checked on every clock. The cause record never holds more than one bit. The state code is always legal and agrees with the requested image. The watchdog pulse lasts one cycle, appears only in user mode and always ends user mode. A halted controller stays halted or starts a load, and image 1 is never requested in the image-0-only variant. Other behaviour needs the directed scenarios. These cover the exact time-out cycle count and the restart by a kick, the revert-then-halt ordering, and the clearing of the revert mark after a requested reload. They also cover priority among simultaneous causes, the override at reconfiguration but not at power-up, and the auto-restart timing.

// File: rtl/cfg_ctrl_pkg.sv
package cfg_ctrl_pkg;

   localparam int NCAUSE    = 4;
   localparam int CAUSE_WD  = 0;
   localparam int CAUSE_STS = 1;
   localparam int CAUSE_CRC = 2;
   localparam int CAUSE_CFG = 3;

   localparam logic [3:0] MSM_NONE     = 4'b0000;
   localparam logic [3:0] MSM_IMG0     = 4'b0010;
   localparam logic [3:0] MSM_IMG1_REV = 4'b0011;
   localparam logic [3:0] MSM_IMG1     = 4'b0100;
   localparam logic [3:0] MSM_IMG0_REV = 4'b0101;

   typedef enum logic [1:0] {
      PH_BOOT = 2'd0,
      PH_LOAD = 2'd1,
      PH_USER = 2'd2,
      PH_HALT = 2'd3
   } phase_e;

   function automatic logic [3:0] msm_code(input logic img, input logic rev);
      if (img) return rev ? MSM_IMG1_REV : MSM_IMG1;
      else     return rev ? MSM_IMG0_REV : MSM_IMG0;
   endfunction

endpackage

// File: rtl/cfg_wdog.sv
module cfg_wdog #(
   parameter int          HI_W   = 12,
   parameter int          LO_W   = 17,
   parameter int unsigned HI_VAL = 4095,
   parameter bit          ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic kick_n_i,
   output logic tmo_o
);
   localparam int CW = HI_W + LO_W;
   localparam logic [CW-1:0] LIMIT = CW'(HI_VAL) << LO_W;
   localparam logic [CW-1:0] LAST  = LIMIT - CW'(1);

   generate
      if (ENABLE) begin : g_on
         logic [CW-1:0] cnt_q;
         logic          kick_q;
         logic          tmo_q;
         logic          kick_fall;

         assign kick_fall = kick_q & ~kick_n_i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               kick_q <= 1'b1;
               tmo_q  <= 1'b0;
            end else begin
               kick_q <= kick_n_i;
               tmo_q  <= run_i && !kick_fall && (cnt_q == LAST);
               if (!run_i || kick_fall) cnt_q <= '0;
               else                     cnt_q <= cnt_q + CW'(1);
            end
         end
         assign tmo_o = tmo_q;
      end else begin : g_off
         assign tmo_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cfg_cause_rec.sv
module cfg_cause_rec
   import cfg_ctrl_pkg::*;
#(
   parameter int NC = NCAUSE,
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_i,
   input  logic [NC-1:0] raw_i,
   input  logic [SW-1:0] state_i,
   output logic [NC-1:0] top_o,
   output logic [NC-1:0] cause_o,
   output logic [SW-1:0] state_o
);
   logic [NC-1:0] cause_q;
   logic [SW-1:0] st_q;

   always_comb begin
      top_o = '0;
      for (int i = NC - 1; i >= 0; i--) begin
         if (raw_i[i] && (top_o == '0)) top_o[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         st_q    <= '0;
      end else if (evt_i) begin
         cause_q <= top_o;
         st_q    <= state_i;
      end
   end

   assign cause_o = cause_q;
   assign state_o = st_q;
endmodule

// File: rtl/cfg_img_sel.sv
module cfg_img_sel #(
   parameter bit IMG0_ONLY = 1'b0
) (
   input  logic pin_i,
   input  logic ovr_en_i,
   input  logic ovr_sel_i,
   output logic boot_img_o,
   output logic rcfg_img_o
);
   generate
      if (IMG0_ONLY) begin : g_fixed
         logic unused_in;
         assign unused_in  = pin_i ^ ovr_en_i ^ ovr_sel_i;
         assign boot_img_o = 1'b0;
         assign rcfg_img_o = 1'b0;
      end else begin : g_pick
         assign boot_img_o = pin_i;
         assign rcfg_img_o = ovr_en_i ? ovr_sel_i : pin_i;
      end
   endgenerate
endmodule

// File: rtl/dual_img_cfg_ctrl.sv
module dual_img_cfg_ctrl
   import cfg_ctrl_pkg::*;
#(
   parameter bit          WD_EN        = 1'b1,
   parameter int          WD_HI_W      = 12,
   parameter int          WD_LO_W      = 17,
   parameter int unsigned WD_HI_VAL    = 4095,
   parameter bit          AUTO_RESTART = 1'b0,
   parameter bit          IMG0_ONLY    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_pin_i,
   input  logic       ovr_en_i,
   input  logic       ovr_sel_i,
   input  logic       ext_cfg_n_i,
   input  logic       ext_sts_n_i,
   input  logic       usr_cfg_n_i,
   input  logic       wd_kick_n_i,
   input  logic       load_done_i,
   input  logic       crc_err_i,
   output logic       load_req_o,
   output logic       load_img_o,
   output logic       user_mode_o,
   output logic       halted_o,
   output logic       wd_timeout_o,
   output logic [3:0] state_o,
   output logic [3:0] prev_cause_o,
   output logic [3:0] prev_state_o
);
   localparam int WD_W = WD_HI_W + WD_LO_W;

   initial begin
      chk_wd_width : assert (WD_HI_W > 0 && WD_LO_W >= 0 && WD_W <= 32)
         else $fatal(1, "watchdog width out of range");
      chk_wd_val : assert (WD_HI_VAL > 0 && WD_HI_VAL < (64'd1 << WD_HI_W))
         else $fatal(1, "watchdog value does not fit its field");
   end

   phase_e      ph_q, n_ph;
   logic        img_q, n_img;
   logic [3:0]  msm_q, n_msm;
   logic        rev_q, n_rev;
   logic        clr_q, n_clr;
   logic        evt, err, rcfg;
   logic        wd_tmo;
   logic        boot_img, rcfg_img;
   logic [NCAUSE-1:0] rec_raw, rec_top;

   cfg_img_sel #(.IMG0_ONLY(IMG0_ONLY)) u_sel (
      .pin_i     (sel_pin_i),
      .ovr_en_i  (ovr_en_i),
      .ovr_sel_i (ovr_sel_i),
      .boot_img_o(boot_img),
      .rcfg_img_o(rcfg_img)
   );

   cfg_wdog #(
      .HI_W  (WD_HI_W),
      .LO_W  (WD_LO_W),
      .HI_VAL(WD_HI_VAL),
      .ENABLE(WD_EN)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (ph_q == PH_USER),
      .kick_n_i(wd_kick_n_i),
      .tmo_o   (wd_tmo)
   );

   always_comb begin
      rec_raw = '0;
      if (ph_q == PH_USER) begin
         rec_raw[CAUSE_CFG] = ~ext_cfg_n_i;
         rec_raw[CAUSE_CRC] = crc_err_i;
         rec_raw[CAUSE_STS] = ~ext_sts_n_i;
         rec_raw[CAUSE_WD]  = wd_tmo;
      end else if (ph_q == PH_LOAD) begin
         rec_raw[CAUSE_CRC] = crc_err_i;
      end
   end

   cfg_cause_rec #(.NC(NCAUSE), .SW(4)) u_rec (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt),
      .raw_i  (rec_raw),
      .state_i(msm_q),
      .top_o  (rec_top),
      .cause_o(prev_cause_o),
      .state_o(prev_state_o)
   );

   always_comb begin
      n_ph  = ph_q;
      n_img = img_q;
      n_msm = msm_q;
      n_rev = rev_q;
      n_clr = clr_q;
      evt   = 1'b0;
      err   = 1'b0;
      rcfg  = 1'b0;
      unique case (ph_q)
         PH_BOOT: begin
            n_img = boot_img;
            n_msm = msm_code(boot_img, 1'b0);
            n_rev = 1'b0;
            n_clr = 1'b0;
            n_ph  = PH_LOAD;
         end
         PH_LOAD: begin
            if (crc_err_i) begin
               evt = 1'b1;
               err = 1'b1;
            end else if (load_done_i) begin
               n_ph = PH_USER;
               if (clr_q) begin
                  n_rev = 1'b0;
                  n_clr = 1'b0;
               end
            end
         end
         PH_USER: begin
            if ((|rec_raw) || !usr_cfg_n_i) begin
               evt = 1'b1;
               if (rec_top[CAUSE_CRC] || rec_top[CAUSE_WD]) err  = 1'b1;
               else                                         rcfg = 1'b1;
            end
         end
         PH_HALT: begin
            if (!ext_cfg_n_i || !ext_sts_n_i || !usr_cfg_n_i || (AUTO_RESTART != 1'b0))
               rcfg = 1'b1;
         end
         default: n_ph = PH_BOOT;
      endcase

      if (err) begin
         if (!rev_q && (IMG0_ONLY == 1'b0)) begin
            n_img = ~img_q;
            n_msm = msm_code(~img_q, 1'b1);
            n_rev = 1'b1;
            n_clr = 1'b0;
            n_ph  = PH_LOAD;
         end else begin
            n_ph  = PH_HALT;
         end
      end
      if (rcfg) begin
         n_img = rcfg_img;
         n_msm = msm_code(rcfg_img, 1'b0);
         n_clr = 1'b1;
         n_ph  = PH_LOAD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_BOOT;
         img_q <= 1'b0;
         msm_q <= MSM_NONE;
         rev_q <= 1'b0;
         clr_q <= 1'b0;
      end else begin
         ph_q  <= n_ph;
         img_q <= n_img;
         msm_q <= n_msm;
         rev_q <= n_rev;
         clr_q <= n_clr;
      end
   end

   assign load_req_o   = (ph_q == PH_LOAD);
   assign load_img_o   = img_q;
   assign user_mode_o  = (ph_q == PH_USER);
   assign halted_o     = (ph_q == PH_HALT);
   assign wd_timeout_o = wd_tmo;
   assign state_o      = msm_q;
endmodule

// File: rtl/dual_img_cfg_ctrl_chk.sv
module dual_img_cfg_ctrl_chk #(
   parameter bit IMG0_ONLY = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       load_done_i,
   input logic       load_req_o,
   input logic       load_img_o,
   input logic       user_mode_o,
   input logic       halted_o,
   input logic       wd_timeout_o,
   input logic [3:0] state_o,
   input logic [3:0] prev_cause_o
);
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      state_o inside {4'b0000, 4'b0010, 4'b0011, 4'b0100, 4'b0101}); // R1
   AST_IMG_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      load_req_o |-> (load_img_o == (state_o == 4'b0100 || state_o == 4'b0011))); // R1
   AST_USER_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_mode_o) |-> $past(load_done_i)); // R3
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> (halted_o || load_req_o)); // R5
   AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(prev_cause_o)); // R7
   AST_TMO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wd_timeout_o |=> !wd_timeout_o); // R8
   AST_TMO_IN_USER: assert property (@(posedge clk) disable iff (!rst_n)
      wd_timeout_o |-> $past(user_mode_o)); // R8
   AST_TMO_ENDS_USER: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_timeout_o && user_mode_o) |=> !user_mode_o); // R4
   AST_IMG0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req_o && IMG0_ONLY) |-> !load_img_o); // R10
endmodule

bind dual_img_cfg_ctrl dual_img_cfg_ctrl_chk #(.IMG0_ONLY(IMG0_ONLY)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .load_done_i (load_done_i),
   .load_req_o  (load_req_o),
   .load_img_o  (load_img_o),
   .user_mode_o (user_mode_o),
   .halted_o    (halted_o),
   .wd_timeout_o(wd_timeout_o),
   .state_o     (state_o),
   .prev_cause_o(prev_cause_o)
);

// File: tb/dual_img_cfg_ctrl_tb.sv
`timescale 1ns/1ps
module dual_img_cfg_ctrl_tb;
   localparam int LO_W  = 4;
   localparam int HI_V  = 3;
   localparam int LIMIT = HI_V << LO_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_pin = 1'b0, ovr_en = 1'b0, ovr_sel = 1'b0;
   logic ext_cfg_n = 1'b1, ext_sts_n = 1'b1, usr_cfg_n = 1'b1, wd_kick_n = 1'b1;
   logic load_done = 1'b0, crc_err = 1'b0;
   logic       a_req, a_img, a_user, a_halt, a_tmo;
   logic [3:0] a_st, a_cause, a_pst;
   logic       b_req, b_img, b_user, b_halt, b_tmo;
   logic [3:0] b_st, b_cause, b_pst;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dual_img_cfg_ctrl #(.WD_LO_W(LO_W), .WD_HI_VAL(HI_V)) u_dut (
      .clk(clk), .rst_n(rst_n), .sel_pin_i(sel_pin), .ovr_en_i(ovr_en), .ovr_sel_i(ovr_sel),
      .ext_cfg_n_i(ext_cfg_n), .ext_sts_n_i(ext_sts_n), .usr_cfg_n_i(usr_cfg_n),
      .wd_kick_n_i(wd_kick_n), .load_done_i(load_done), .crc_err_i(crc_err),
      .load_req_o(a_req), .load_img_o(a_img), .user_mode_o(a_user), .halted_o(a_halt),
      .wd_timeout_o(a_tmo), .state_o(a_st), .prev_cause_o(a_cause), .prev_state_o(a_pst));

   dual_img_cfg_ctrl #(.WD_LO_W(LO_W), .WD_HI_VAL(HI_V), .AUTO_RESTART(1'b1), .IMG0_ONLY(1'b1)) u_dut_b (
      .clk(clk), .rst_n(rst_n), .sel_pin_i(sel_pin), .ovr_en_i(ovr_en), .ovr_sel_i(ovr_sel),
      .ext_cfg_n_i(ext_cfg_n), .ext_sts_n_i(ext_sts_n), .usr_cfg_n_i(usr_cfg_n),
      .wd_kick_n_i(wd_kick_n), .load_done_i(load_done), .crc_err_i(crc_err),
      .load_req_o(b_req), .load_img_o(b_img), .user_mode_o(b_user), .halted_o(b_halt),
      .wd_timeout_o(b_tmo), .state_o(b_st), .prev_cause_o(b_cause), .prev_state_o(b_pst));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic finish_load();
      load_done = 1'b1;
      step();
      load_done = 1'b0;
   endtask

   task automatic count_to_tmo(output int n);
      n = 0;
      while (!a_tmo && n < 200) begin
         step();
         n++;
      end
   endtask

   task automatic do_reset(input logic sel);
      rst_n = 1'b0;
      sel_pin = sel; ovr_en = 1'b0; ovr_sel = 1'b0;
      ext_cfg_n = 1'b1; ext_sts_n = 1'b1; usr_cfg_n = 1'b1; wd_kick_n = 1'b1;
      load_done = 1'b0; crc_err = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
   endtask

   task automatic t_boot();
      do_reset(1'b1);
      chk("R2 reset outputs", {a_req, a_user, a_halt, a_cause, a_st}, 11'h000);
      step();
      chk("R2 boot load of pin image", {a_req, a_img, a_st}, {1'b1, 1'b1, 4'b0100});
      finish_load();
      chk("R3 user mode after done", {a_req, a_user}, 2'b01);
   endtask

   task automatic t_watchdog_revert();
      int n;
      count_to_tmo(n);
      chk("R8 timeout cycle count", n, LIMIT);
      step();
      chk("R8 timeout pulse width", a_tmo, 1'b0);
      chk("R4 revert to image 0", {a_req, a_img, a_st}, {1'b1, 1'b0, 4'b0101});
      chk("R7 watchdog cause record", {a_cause, a_pst}, {4'b0001, 4'b0100});
   endtask

   task automatic t_second_error();
      finish_load();
      crc_err = 1'b1; step(); crc_err = 1'b0;
      chk("R5 halt on second error", {a_halt, a_req}, 2'b10);
      chk("R7 crc cause record", {a_cause, a_pst}, {4'b0100, 4'b0101});
      repeat (3) step();
      chk("R5 halt held without request", {a_halt, a_req}, 2'b10);
      sel_pin = 1'b0;
      ext_sts_n = 1'b0; step(); ext_sts_n = 1'b1;
      chk("R6 status request reloads pin image", {a_req, a_img, a_st}, {1'b1, 1'b0, 4'b0010});
      chk("R7 no record when leaving halt", a_cause, 4'b0100);
      finish_load();
      crc_err = 1'b1; step(); crc_err = 1'b0;
      chk("R12 revert allowed again after requested reload", {a_req, a_img, a_st}, {1'b1, 1'b1, 4'b0011});
   endtask

   task automatic t_kick();
      int n;
      bit seen = 1'b0;
      finish_load();
      for (int k = 0; k < 5; k++) begin
         for (int c = 0; c < 30; c++) begin
            step();
            if (a_tmo) seen = 1'b1;
         end
         wd_kick_n = 1'b0; step(); wd_kick_n = 1'b1;
         if (a_tmo) seen = 1'b1;
      end
      chk("R9 kicks prevent timeout", seen, 1'b0);
      count_to_tmo(n);
      chk("R9 count restarts at kick", n, LIMIT);
      step();
      chk("R5 watchdog after revert halts", {a_halt, a_cause, a_pst}, {1'b1, 4'b0001, 4'b0011});
   endtask

   task automatic t_priority();
      ovr_en = 1'b1; ovr_sel = 1'b1;
      usr_cfg_n = 1'b0; step(); usr_cfg_n = 1'b1;
      chk("R11 override picks image 1", {a_req, a_img, a_st}, {1'b1, 1'b1, 4'b0100});
      finish_load();
      ext_cfg_n = 1'b0; ext_sts_n = 1'b0; crc_err = 1'b1;
      step();
      ext_cfg_n = 1'b1; ext_sts_n = 1'b1; crc_err = 1'b0;
      chk("R7 config outranks crc and status", {a_cause, a_pst}, {4'b1000, 4'b0100});
      chk("R6 config request reloads", {a_req, a_img, a_st}, {1'b1, 1'b1, 4'b0100});
      finish_load();
      crc_err = 1'b1; ext_sts_n = 1'b0;
      step();
      crc_err = 1'b0; ext_sts_n = 1'b1;
      chk("R7 crc outranks status", a_cause, 4'b0100);
      chk("R12 error after requested reload reverts", {a_req, a_img, a_st}, {1'b1, 1'b0, 4'b0101});
      finish_load();
      usr_cfg_n = 1'b0; step(); usr_cfg_n = 1'b1;
      chk("R7 user request records no cause", {a_cause, a_pst}, {4'b0000, 4'b0101});
      chk("R6 user request reloads override image", {a_req, a_img, a_st}, {1'b1, 1'b1, 4'b0100});
      finish_load();
      ovr_en = 1'b0;
   endtask

   task automatic t_img0_only();
      do_reset(1'b1);
      ovr_en = 1'b1; ovr_sel = 1'b1;
      step();
      chk("R11 override unused at power-up", {a_img, a_st}, {1'b1, 4'b0100});
      chk("R10 fixed image 0 at boot", {b_req, b_img, b_st}, {1'b1, 1'b0, 4'b0010});
      crc_err = 1'b1; step(); crc_err = 1'b0;
      chk("R4 crc during load reverts", {a_req, a_img, a_st}, {1'b1, 1'b0, 4'b0101});
      chk("R10 no fallback to image 1", {b_halt, b_req}, 2'b10);
      step();
      chk("R5 auto restart reload", {b_req, b_img, b_st}, {1'b1, 1'b0, 4'b0010});
   endtask

   initial begin
      t_boot();
      t_watchdog_revert();
      t_second_error();
      t_kick();
      t_priority();
      t_img0_only();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule